// File: doc/BRIEF.md
# Serial Audio Bit and Frame Clock Generator

This block takes the codec master clock as its only clock and derives from it the two serial-audio timing clocks: the bit clock and the word-select (left/right) clock. The master clock runs at either 256 or 384 times the sample rate. A single input picks the ratio, and that input is captured while reset is held. The number of bit-clock periods in each channel slot is a parameter, so the bit clock always runs at twice the sample rate times the slot width. Typical sample rates are 44.1 kHz and 48 kHz.

Serial data logic in the master-clock domain does not need to detect the clock edges itself. The block supplies one-cycle strobes that mark the master-clock cycle in which the bit clock falls (the cycle in which to launch data) and the cycle in which it rises (the cycle in which to sample data). A third strobe marks the start of each frame, where word-select returns to the left channel. The master clock is generated outside this block.

Some pairings of ratio and slot width give no even whole-number divider. For such a pairing the block raises a configuration error and keeps every clock and strobe low.

Top module: `i2s_clkgen`

## Requirements
- R1: While rst_n is low, bclk, lrck, launch_stb, sample_stb and frame_stb are all 0, and this holds at once when reset is applied during operation. After release, bclk first rises on the H-th rising mclk edge, where H is half the divider.
- R2: ratio_sel is captured while rst_n is low (0 selects 256 mclk per sample, 1 selects 384). A change of ratio_sel while out of reset has no effect on any output.
- R3: bclk has a period of D = ratio/(2*SLOT_BITS) mclk cycles. It is high for H = D/2 cycles and low for H cycles. After the k-th rising mclk edge since release, bclk equals floor(k/H) mod 2.
- R4: lrck starts low (left channel) after reset. It changes only in the cycle in which bclk falls, and toggles once every SLOT_BITS bclk periods, so that lrck equals floor(k/(2*H*SLOT_BITS)) mod 2. High means the right channel.
- R5: launch_stb is 1 for exactly the mclk cycles in which bclk has just gone from 1 to 0.
- R6: sample_stb is 1 for exactly the mclk cycles in which bclk has just gone from 0 to 1.
- R7: frame_stb is 1 for exactly the mclk cycles in which lrck has just gone from 1 to 0. This happens once per 2*SLOT_BITS bclk periods.
- R8: If the selected ratio is not a multiple of 2*SLOT_BITS, or the quotient D is odd or below 2, then cfg_err is 1 and bclk, lrck and all strobes stay 0. Otherwise cfg_err is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| mclk | input | 1 | Master clock, 256 or 384 times the sample rate |
| rst_n | input | 1 | Asynchronous active-low reset; the ratio is captured while low |
| ratio_sel | input | 1 | Ratio select: 0 for 256, 1 for 384 |
| bclk | output | 1 | Bit clock |
| lrck | output | 1 | Word select: 0 for left, 1 for right |
| launch_stb | output | 1 | One-cycle pulse in the cycle in which bclk falls |
| sample_stb | output | 1 | One-cycle pulse in the cycle in which bclk rises |
| frame_stb | output | 1 | One-cycle pulse in the cycle in which lrck falls |
| cfg_err | output | 1 | The selected ratio gives no valid even divider |

## Verification
The hardest condition to reach from the ports is the invalid-divider case, because the default 32-bit slot gives even dividers for both ratios. The bench therefore runs a second instance with 24-bit slots. With that width, 256 does not divide evenly while 384 gives a divider of 8, so the same bench checks both the rejected and the accepted branch. Reset is also applied while bclk is high in the middle of a frame, to confirm that the outputs drop at once. The ratio input is toggled while running, and the bench checks that the clock pattern stays on its original divider.

// File: rtl/i2s_clkgen_pkg.sv
package i2s_clkgen_pkg;

  // Half of the bclk divider for a given ratio and slot width; 0 marks an
  // unusable pairing (no whole quotient, odd quotient or quotient below 2).
  function automatic int unsigned half_div(int unsigned ratio, int unsigned slot);
    int unsigned d;
    if (slot == 0) return 0;
    if ((ratio % (2 * slot)) != 0) return 0;
    d = ratio / (2 * slot);
    if ((d < 2) || ((d % 2) != 0)) return 0;
    return d / 2;
  endfunction

  function automatic int unsigned max_u(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction

  typedef enum logic { RATIO_256 = 1'b0, RATIO_384 = 1'b1 } ratio_e;

endpackage

// File: rtl/i2s_clkgen_cfg.sv
module i2s_clkgen_cfg
  import i2s_clkgen_pkg::*;
#(
  parameter int unsigned SLOT_BITS = 32,
  parameter int unsigned RATIO_LO  = 256,
  parameter int unsigned RATIO_HI  = 384,
  parameter int unsigned HW        = 2
) (
  input  logic          mclk,
  input  logic          rst_n,
  input  logic          ratio_sel,
  output logic [HW-1:0] half,
  output logic          cfg_ok
);

  logic [HW-1:0] half_tab [2];
  ratio_e        sel_q;

  for (genvar g = 0; g < 2; g++) begin : g_ratio
    localparam int unsigned RSEL = (g == 0) ? RATIO_LO : RATIO_HI;
    localparam int unsigned HVAL = half_div(RSEL, SLOT_BITS);
    assign half_tab[g] = HW'(HVAL);
  end

  // Ratio is loaded only while reset is held; frozen during operation.
  always_ff @(posedge mclk) begin
    if (!rst_n) sel_q <= ratio_e'(ratio_sel);
  end

  assign half   = half_tab[sel_q];
  assign cfg_ok = (half != '0);

endmodule

// File: rtl/i2s_bclk_div.sv
module i2s_bclk_div #(
  parameter int unsigned HW = 2
) (
  input  logic          mclk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [HW-1:0] half,
  output logic          bclk,
  output logic          fall_next,
  output logic          launch_stb,
  output logic          sample_stb
);

  logic [HW-1:0] hcnt;
  logic          wrap;

  assign wrap      = en && (hcnt == (half - HW'(1)));
  assign fall_next = wrap && bclk;

  always_ff @(posedge mclk or negedge rst_n) begin
    if (!rst_n) begin
      hcnt       <= '0;
      bclk       <= 1'b0;
      launch_stb <= 1'b0;
      sample_stb <= 1'b0;
    end else if (!en) begin
      hcnt       <= '0;
      bclk       <= 1'b0;
      launch_stb <= 1'b0;
      sample_stb <= 1'b0;
    end else if (wrap) begin
      hcnt       <= '0;
      bclk       <= ~bclk;
      launch_stb <= bclk;
      sample_stb <= ~bclk;
    end else begin
      hcnt       <= hcnt + HW'(1);
      launch_stb <= 1'b0;
      sample_stb <= 1'b0;
    end
  end

endmodule

// File: rtl/i2s_lrck_seq.sv
module i2s_lrck_seq #(
  parameter int unsigned SLOT_BITS = 32
) (
  input  logic mclk,
  input  logic rst_n,
  input  logic en,
  input  logic fall_next,
  output logic lrck,
  output logic frame_stb
);

  localparam int unsigned BW = (SLOT_BITS < 2) ? 1 : $clog2(SLOT_BITS);
  localparam logic [BW-1:0] LAST = BW'(SLOT_BITS - 1);

  logic [BW-1:0] bitcnt;

  always_ff @(posedge mclk or negedge rst_n) begin
    if (!rst_n) begin
      bitcnt    <= '0;
      lrck      <= 1'b0;
      frame_stb <= 1'b0;
    end else if (!en) begin
      bitcnt    <= '0;
      lrck      <= 1'b0;
      frame_stb <= 1'b0;
    end else if (fall_next) begin
      if (bitcnt == LAST) begin
        bitcnt    <= '0;
        lrck      <= ~lrck;
        frame_stb <= lrck;
      end else begin
        bitcnt    <= bitcnt + BW'(1);
        frame_stb <= 1'b0;
      end
    end else begin
      frame_stb <= 1'b0;
    end
  end

endmodule

// File: rtl/i2s_clkgen.sv
module i2s_clkgen
  import i2s_clkgen_pkg::*;
#(
  parameter int unsigned SLOT_BITS = 32,
  parameter int unsigned RATIO_LO  = 256,
  parameter int unsigned RATIO_HI  = 384
) (
  input  logic mclk,
  input  logic rst_n,
  input  logic ratio_sel,
  output logic bclk,
  output logic lrck,
  output logic launch_stb,
  output logic sample_stb,
  output logic frame_stb,
  output logic cfg_err
);

  localparam int unsigned HMAX = max_u(half_div(RATIO_LO, SLOT_BITS),
                                       half_div(RATIO_HI, SLOT_BITS));
  localparam int unsigned HW   = (HMAX < 2) ? 1 : $clog2(HMAX + 1);

  logic [HW-1:0] half;
  logic          cfg_ok;
  logic          fall_next;

  i2s_clkgen_cfg #(
    .SLOT_BITS(SLOT_BITS), .RATIO_LO(RATIO_LO), .RATIO_HI(RATIO_HI), .HW(HW)
  ) u_cfg (
    .mclk(mclk), .rst_n(rst_n), .ratio_sel(ratio_sel),
    .half(half), .cfg_ok(cfg_ok)
  );

  i2s_bclk_div #(.HW(HW)) u_div (
    .mclk(mclk), .rst_n(rst_n), .en(cfg_ok), .half(half),
    .bclk(bclk), .fall_next(fall_next),
    .launch_stb(launch_stb), .sample_stb(sample_stb)
  );

  i2s_lrck_seq #(.SLOT_BITS(SLOT_BITS)) u_seq (
    .mclk(mclk), .rst_n(rst_n), .en(cfg_ok), .fall_next(fall_next),
    .lrck(lrck), .frame_stb(frame_stb)
  );

  assign cfg_err = ~cfg_ok;

endmodule

// File: rtl/i2s_clkgen_chk.sv
module i2s_clkgen_chk (
  input logic mclk,
  input logic rst_n,
  input logic bclk,
  input logic lrck,
  input logic launch_stb,
  input logic sample_stb,
  input logic frame_stb,
  input logic cfg_err
);

  // R5
  launch_on_fall_chk: assert property (@(posedge mclk) disable iff (!rst_n)
    launch_stb |-> $fell(bclk));

  // R6
  sample_on_rise_chk: assert property (@(posedge mclk) disable iff (!rst_n)
    sample_stb |-> $rose(bclk));

  // R7
  frame_on_lrck_fall_chk: assert property (@(posedge mclk) disable iff (!rst_n)
    frame_stb |-> $fell(lrck));

  // R4
  lrck_moves_with_fall_chk: assert property (@(posedge mclk) disable iff (!rst_n)
    !$stable(lrck) |-> (launch_stb && $fell(bclk)));

  // R8
  err_silences_outputs_chk: assert property (@(posedge mclk) disable iff (!rst_n)
    cfg_err |-> (!bclk && !lrck && !launch_stb && !sample_stb && !frame_stb));

  // R3
  strobes_exclusive_chk: assert property (@(posedge mclk) disable iff (!rst_n)
    $countones({launch_stb, sample_stb}) <= 1);

endmodule

bind i2s_clkgen i2s_clkgen_chk u_chk (
  .mclk(mclk), .rst_n(rst_n), .bclk(bclk), .lrck(lrck),
  .launch_stb(launch_stb), .sample_stb(sample_stb),
  .frame_stb(frame_stb), .cfg_err(cfg_err)
);

// File: tb/test_i2s_clkgen.sv
`timescale 1ns/1ps
module test_i2s_clkgen;

  logic mclk = 1'b0;
  logic rst_n = 1'b0;
  logic sel_a = 1'b0;
  logic sel_b = 1'b0;
  logic bclk_a, lrck_a, lst_a, sst_a, fst_a, err_a;
  logic bclk_b, lrck_b, lst_b, sst_b, fst_b, err_b;

  int n_chk = 0;
  int n_bad = 0;
  bit active = 1'b0;
  bit done = 1'b0;
  string phase_tag = "R3";

  logic [5:0] q_a [$];
  logic [5:0] q_b [$];

  always #10 mclk = ~mclk;

  i2s_clkgen #(.SLOT_BITS(32)) i_i2s_clkgen (
    .mclk(mclk), .rst_n(rst_n), .ratio_sel(sel_a),
    .bclk(bclk_a), .lrck(lrck_a), .launch_stb(lst_a), .sample_stb(sst_a),
    .frame_stb(fst_a), .cfg_err(err_a)
  );

  // 24-bit slots: 256 is rejected, 384 gives a divider of 8
  i2s_clkgen #(.SLOT_BITS(24)) i_i2s_clkgen_s24 (
    .mclk(mclk), .rst_n(rst_n), .ratio_sel(sel_b),
    .bclk(bclk_b), .lrck(lrck_b), .launch_stb(lst_b), .sample_stb(sst_b),
    .frame_stb(fst_b), .cfg_err(err_b)
  );

  // Expected {cfg_err, bclk, lrck, launch, sample, frame} after edge k (k>=1).
  function automatic logic [5:0] model(int k, int h, int slot);
    logic [5:0] v;
    if (h == 0) return 6'b100000;
    v[5] = 1'b0;
    v[4] = ((k / h) % 2) == 1;
    v[3] = ((k / (2 * h * slot)) % 2) == 1;
    v[2] = (k % (2 * h)) == 0;
    v[1] = (k % (2 * h)) == h;
    v[0] = (k % (4 * h * slot)) == 0;
    return v;
  endfunction

  function automatic string field_req(logic [5:0] d);
    if (d[5]) return "R8";
    if (d[4]) return "R3";
    if (d[3]) return "R4";
    if (d[2]) return "R5";
    if (d[1]) return "R6";
    return "R7";
  endfunction

  task automatic compare(string who, logic [5:0] act, logic [5:0] exp, string req);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s (%s): actual %b expected %b", req, who, phase_tag, act, exp);
    end
  endtask

  // Monitor: pops one expected vector per instance each cycle.
  always @(negedge mclk) begin
    if (active) begin
      if (q_a.size() > 0) begin
        logic [5:0] e, a;
        e = q_a.pop_front();
        a = {err_a, bclk_a, lrck_a, lst_a, sst_a, fst_a};
        compare("inst32", a, e, field_req(a ^ e));
      end
      if (q_b.size() > 0) begin
        logic [5:0] e, a;
        e = q_b.pop_front();
        a = {err_b, bclk_b, lrck_b, lst_b, sst_b, fst_b};
        compare("inst24", a, e, field_req(a ^ e));
      end
    end
  end

  // Driver: capture ratio in reset, push the expected stream, run, re-reset.
  task automatic run_phase(bit sa, bit sb, int n, int toggle_at);
    int ha, hb;
    sel_a = sa;
    sel_b = sb;
    repeat (3) @(negedge mclk);
    // R1 reset state, R8 flag already decided from captured ratio
    compare("inst32", {err_a, bclk_a, lrck_a, lst_a, sst_a, fst_a}, 6'b000000, "R1");
    compare("inst24", {err_b, bclk_b, lrck_b, lst_b, sst_b, fst_b},
            sb ? 6'b000000 : 6'b100000, "R8");
    ha = sa ? 3 : 2;
    hb = sb ? 4 : 0;
    for (int k = 1; k <= n; k++) begin
      q_a.push_back(model(k, ha, 32));
      q_b.push_back(model(k, hb, 24));
    end
    rst_n = 1'b1;
    #1 active = 1'b1;
    if (toggle_at > 0) begin
      repeat (toggle_at) @(negedge mclk);
      #2;
      sel_a = ~sel_a;
      sel_b = ~sel_b;
      phase_tag = "R2";
    end
    wait (q_a.size() == 0 && q_b.size() == 0);
    active = 1'b0;
    #3 rst_n = 1'b0;
    #1;
    // R1: outputs drop at once when reset hits mid-frame with bclk high
    compare("inst32", {bclk_a, lrck_a, lst_a, sst_a, fst_a, 1'b0}, 6'b0, "R1");
    compare("inst24", {bclk_b, lrck_b, lst_b, sst_b, fst_b, 1'b0}, 6'b0, "R1");
    phase_tag = "R3";
  endtask

  initial begin
    repeat (4) @(negedge mclk);
    run_phase(1'b0, 1'b0, 702, 50);
    run_phase(1'b1, 1'b1, 1000, 300);
    run_phase(1'b0, 1'b1, 802, 0);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        #(200000 * 20);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual hung expected finished");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule